// File: doc/BRIEF.md
# Vector Tree Reduction Sequencer

This block collapses a vector of integer partial sums into one scalar by repeated halving. A start pulse carries a vector length `VL` and a chunk count. The block clears an internal partial-sum vector of `VL` entries. It then takes `chunks * VL` input elements from a valid-qualified stream. Accepted element number `i` of each chunk is added into entry `i`, so each chunk lands element-wise on the same `VL` entries.

Once the last element is in, the block reduces the vector with a binary tree. Each pass halves the live length. Entry `j + half` is added into entry `j` for every `j < half`, using `P` adders per cycle. When a single entry remains, its value is presented on the result port together with a one-cycle done pulse.

Because integer addition wraps modulo 2^W and is associative, the result equals a plain sequential sum of every accepted element. Lengths that are zero, not a power of two, or larger than the vector capacity are refused. A zero chunk count is refused too. Each refusal raises an error pulse.

Top module: `vred_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are 0 and `sum_o` is 0.
- R2: A start whose length is 0, is not a power of two, or exceeds `VLMAX`, or whose chunk count is 0, gives a one-cycle `err_o` pulse in the cycle after the start edge. In that case the block stays idle (`busy_o` = 0) and `done_o` does not assert.
- R3: After a valid start, exactly `chunks * VL` elements are accepted. Only cycles with `in_valid_i` = 1 count, so idle gaps in the stream do not change the result.
- R4: `sum_o` equals the sequential sum of all accepted elements modulo 2^W, including when the true sum overflows W bits.
- R5: For `VL` > 1, `done_o` rises `1 + Σ ceil(h/P)` clock edges after the edge that accepts the last element. The sum runs over the pass lengths h = VL/2, VL/4, …, 1.
- R6: With `VL` = 1 no tree pass runs: `done_o` rises on the first edge after the last element is accepted, carrying the sum of all elements.
- R7: `done_o` is high for exactly one cycle per accepted start, and `sum_o` holds the result during that cycle.
- R8: A start pulse while `busy_o` = 1 is ignored and does not change the running reduction. `in_valid_i` while idle is ignored and does not change the next result.
- R9: During the tree phase the live length is always a power of two greater than 1, and from one cycle to the next it either stays the same or halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| vl_i | input | $clog2(VLMAX)+1 | Vector length for this reduction |
| chunks_i | input | CW | Number of VL-sized chunks in the input stream |
| in_valid_i | input | 1 | Input element valid |
| in_data_i | input | W | Input element |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| sum_o | output | W | Reduction result |

## Verification
The main function is tried with several stream patterns:
- an incrementing ramp;
- a scrambled XOR pattern;
- a descending pattern;
- all-ones data whose true sum overflows, which separates wrapping arithmetic from saturating or truncated-partial behaviour.

Lengths 16, 8, 4, 2 and 1 with one to five chunks check the pass count and the per-pass cost `ceil(h/P)`. Those results are compared against a sequential sum, so any lost or doubled entry in a pass shows up. Runs with bubbles in the input stream check that only valid cycles are counted. A run with a start pulse injected mid-stream checks that busy starts are ignored.

// File: rtl/vred_pkg.sv
package vred_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACC  = 2'd1,
        S_TREE = 2'd2,
        S_DONE = 2'd3
    } vred_state_e;
endpackage

// File: rtl/vred_len_check.sv
module vred_len_check #(
    parameter int VLMAX = 16,
    parameter int LW    = $clog2(VLMAX) + 1
) (
    input  logic [LW-1:0] len_i,
    output logic          ok_o
);
    logic nonzero;
    logic single_bit;
    logic in_range;

    always_comb begin
        nonzero    = (len_i != '0);
        single_bit = ((len_i & (len_i - LW'(1))) == '0);
        in_range   = ({1'b0, len_i} <= (LW+1)'(VLMAX));
        ok_o       = nonzero && single_bit && in_range;
    end
endmodule

// File: rtl/vred_lanes.sv
module vred_lanes #(
    parameter int W = 16,
    parameter int P = 2
) (
    input  logic [P-1:0][W-1:0] lo_i,
    input  logic [P-1:0][W-1:0] hi_i,
    output logic [P-1:0][W-1:0] sum_o
);
    for (genvar k = 0; k < P; k++) begin : g_lane
        assign sum_o[k] = lo_i[k] + hi_i[k];
    end
endmodule

// File: rtl/vred_seq.sv
module vred_seq
    import vred_pkg::*;
#(
    parameter int W     = 16,
    parameter int VLMAX = 16,
    parameter int P     = 2,
    parameter int CW    = 4,
    localparam int LW   = $clog2(VLMAX) + 1,
    localparam int AW   = $clog2(VLMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LW-1:0] vl_i,
    input  logic [CW-1:0] chunks_i,
    input  logic          in_valid_i,
    input  logic [W-1:0]  in_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [W-1:0]  sum_o
);
    typedef struct packed {
        vred_state_e                st;
        logic [VLMAX-1:0][W-1:0]    vec;
        logic [LW-1:0]              len;
        logic [LW-1:0]              idx;
        logic [CW-1:0]              left;
        logic [W-1:0]               sum;
        logic                       done;
        logic                       err;
    } regs_t;

    regs_t r_q, r_d;

    logic                 len_ok;
    logic [LW-1:0]        half;
    logic [P-1:0][W-1:0]  lane_lo, lane_hi, lane_sum;
    logic [P-1:0]         lane_en;
    logic [P-1:0][LW:0]   lane_j;

    vred_len_check #(.VLMAX(VLMAX), .LW(LW)) u_chk (
        .len_i (vl_i),
        .ok_o  (len_ok)
    );

    vred_lanes #(.W(W), .P(P)) u_lanes (
        .lo_i  (lane_lo),
        .hi_i  (lane_hi),
        .sum_o (lane_sum)
    );

    // Operand selection for the P adders of the current tree pass
    always_comb begin
        half = r_q.len >> 1;
        for (int k = 0; k < P; k++) begin
            lane_j[k]  = {1'b0, r_q.idx} + (LW+1)'(k);
            lane_en[k] = (lane_j[k] < {1'b0, half});
            lane_lo[k] = '0;
            lane_hi[k] = '0;
            if (lane_en[k]) begin
                lane_lo[k] = r_q.vec[lane_j[k][AW-1:0]];
                lane_hi[k] = r_q.vec[lane_j[k][AW-1:0] + half[AW-1:0]];
            end
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (!len_ok || chunks_i == '0) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st   = S_ACC;
                        r_d.vec  = '0;
                        r_d.len  = vl_i;
                        r_d.idx  = '0;
                        r_d.left = chunks_i;
                    end
                end
            end
            S_ACC: begin
                if (in_valid_i) begin
                    r_d.vec[r_q.idx[AW-1:0]] = r_q.vec[r_q.idx[AW-1:0]] + in_data_i;
                    if (r_q.idx == r_q.len - LW'(1)) begin
                        r_d.idx  = '0;
                        r_d.left = r_q.left - CW'(1);
                        if (r_q.left == CW'(1)) begin
                            r_d.st = (r_q.len == LW'(1)) ? S_DONE : S_TREE;
                        end
                    end else begin
                        r_d.idx = r_q.idx + LW'(1);
                    end
                end
            end
            S_TREE: begin
                for (int k = 0; k < P; k++) begin
                    if (lane_en[k]) begin
                        r_d.vec[lane_j[k][AW-1:0]] = lane_sum[k];
                    end
                end
                if ({1'b0, r_q.idx} + (LW+1)'(P) >= {1'b0, half}) begin
                    r_d.idx = '0;
                    r_d.len = half;
                    if (half == LW'(1)) begin
                        r_d.st = S_DONE;
                    end
                end else begin
                    r_d.idx = r_q.idx + LW'(P);
                end
            end
            S_DONE: begin
                r_d.done = 1'b1;
                r_d.sum  = r_q.vec[0];
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != S_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
    assign sum_o  = r_q.sum;

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r2_err_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !done_o));

    a_r9_len_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_TREE) |-> ($countones(r_q.len) == 1 && r_q.len > LW'(1)));

    a_r9_len_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_TREE) |=> (r_q.len == $past(r_q.len) || r_q.len == ($past(r_q.len) >> 1)));

    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ACC && start_i) |=> (r_q.len == $past(r_q.len) && r_q.left <= $past(r_q.left)));
endmodule

// File: tb/vred_seq_test.sv
`timescale 1ns/1ps
module vred_seq_test;
    localparam int W     = 16;
    localparam int VLMAX = 16;
    localparam int P     = 2;
    localparam int CW    = 4;
    localparam int LW    = $clog2(VLMAX) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] vl_i = '0;
    logic [CW-1:0] chunks_i = '0;
    logic          in_valid_i = 1'b0;
    logic [W-1:0]  in_data_i = '0;
    logic          busy_o, done_o, err_o;
    logic [W-1:0]  sum_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] exp_q[$];
    logic prev_done = 1'b0;

    always #5 clk = ~clk;

    vred_seq #(.W(W), .VLMAX(VLMAX), .P(P), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .chunks_i(chunks_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .sum_o(sum_o)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int p, input int k);
        case (p)
            0:       return W'(k + 1);
            1:       return W'((k * 37) ^ 16'h5A5A);
            2:       return 16'hFFFF;
            default: return W'(16'h8000 - k * 3);
        endcase
    endfunction

    function automatic int exp_latency(input int vl);
        int h = vl;
        int c = 0;
        while (h > 1) begin
            h = h / 2;
            c += (h + P - 1) / P;
        end
        return c + 1;
    endfunction

    // Monitor: pops the scoreboard on every done pulse (R4, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done)
                check(1'b0, "R7 done longer than one cycle", 2, 1);
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(sum_o == e, "R4 result", sum_o, e);
                end
            end
            prev_done <= done_o;
        end
    end

    task automatic run(input int vl, input int ch, input int p, input bit gaps, input bit poke);
        logic [W-1:0] acc = '0;
        int n;
        int total = vl * ch;
        @(negedge clk);
        start_i = 1'b1; vl_i = LW'(vl); chunks_i = CW'(ch);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R3 busy after valid start", busy_o, 1);
        for (int k = 0; k < total; k++) begin
            if (gaps && (k % 3 == 1)) begin
                in_valid_i = 1'b0; in_data_i = 16'h7777;
                @(negedge clk);
            end
            in_valid_i = 1'b1;
            in_data_i  = pat(p, k);
            acc        = acc + pat(p, k);
            if (poke && k == 1) begin
                start_i = 1'b1; vl_i = LW'(2); chunks_i = CW'(1);   // R8 busy start
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        in_valid_i = 1'b0;
        exp_q.push_back(acc);
        n = 0;
        while (!done_o && n < 64) begin
            @(negedge clk);
            n++;
        end
        if (vl == 1)
            check(n == 1, "R6 no-pass latency", n, 1);
        else
            check(n == exp_latency(vl), "R5 tree latency", n, exp_latency(vl));
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R7 idle after done", busy_o, 0);
    endtask

    task automatic bad_start(input int vl, input int ch);
        @(negedge clk);
        start_i = 1'b1; vl_i = LW'(vl); chunks_i = CW'(ch);
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1, "R2 err pulse", err_o, 1);
        check(busy_o == 1'b0, "R2 stays idle", busy_o, 0);
        @(negedge clk);
        check(err_o == 1'b0 && done_o == 1'b0, "R2 err one cycle, no done", err_o, 0);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && err_o == 0 && sum_o == 0, "R1 reset state", sum_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && done_o == 0 && err_o == 0, "R1 idle after reset", busy_o, 0);

        bad_start(0, 1);
        bad_start(3, 1);
        bad_start(12, 2);
        bad_start(17, 1);
        bad_start(8, 0);

        // R8: in_valid while idle must not leak into the next result
        for (int k = 0; k < 3; k++) begin
            in_valid_i = 1'b1; in_data_i = 16'h1234;
            @(negedge clk);
            check(busy_o == 0 && done_o == 0, "R8 idle input ignored", busy_o, 0);
        end
        in_valid_i = 1'b0;

        run(16, 1, 0, 0, 0);   // R5 full length
        run(16, 3, 1, 0, 0);   // R3 multiple chunks
        run(8,  2, 3, 1, 0);   // R3 gaps in stream
        run(4,  1, 0, 0, 1);   // R8 start while busy
        run(2,  2, 1, 0, 0);
        run(1,  5, 0, 0, 0);   // R6 single element
        run(16, 4, 2, 0, 0);   // R4 wrap with all-ones
        run(8,  1, 2, 1, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 every start produced done", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule